// File: doc/BRIEF.md
# Conditional Jump Program Counter

This block holds the instruction address of a small 16-bit processor and chooses, at every rising clock edge, where that address goes next. The sequencer compares the current ALU result with zero, which puts the result into exactly one of three classes: negative, zero or positive. A three-bit jump mask states which of those classes should cause a branch. When the instruction being executed is a computation instruction and the class of the result is enabled in the mask, the counter loads the branch target supplied from the address register. In every other case the counter moves forward by one.

A synchronous clear overrides everything else. The block is controlled by a small enumerated step decision that has three named states:

- `STEP_CLEAR` is chosen when reset is high.
- `STEP_BRANCH` is chosen when the jump condition holds for a computation instruction.
- `STEP_ADVANCE` is chosen in every other case.

Each clock edge applies exactly one of these transitions to the counter register. The ALU, the register file and instruction fetch sit outside this block.

Top module: `pcj_jump_pc`

## Requirements
- R1: When `rst` is high at a rising edge, `pc_out` becomes 0x0000 after that edge, even if a jump condition holds in the same cycle.
- R2: Mask bit 2 (value 3'b100) enables a jump when `alu_result` is negative, meaning bit 15 is 1.
- R3: Mask bit 1 (value 3'b010) enables a jump when `alu_result` equals 0x0000.
- R4: Mask bit 0 (value 3'b001) enables a jump when `alu_result` is positive, meaning bit 15 is 0 and the value is not zero.
- R5: For a computation instruction, mask 3'b111 jumps for every result and mask 3'b000 never jumps.
- R6: When `is_compute` is low, the counter never jumps, whatever the mask and the result.
- R7: A taken jump loads `jump_target` into `pc_out` at the next edge.
- R8: When no reset and no jump occur, `pc_out` increases by one at the next edge, and 0xFFFF wraps to 0x0000.
- R9: The jump condition is the OR over the three mask bits, each bit combined with its own relation. A mask with a single bit set jumps only for the class that bit enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous clear with the highest priority |
| alu_result | input | 16 | Current ALU result, compared with zero |
| jump_target | input | 16 | Branch target taken from the address register |
| is_compute | input | 1 | High for a computation instruction |
| jump_mask | input | 3 | Jump enables: bit 2 for negative, bit 1 for zero, bit 0 for positive |
| pc_out | output | 16 | Registered program counter |

## Verification
Two of the block's functions can fall in the same cycle: the synchronous clear and a taken branch. The bench provokes this by raising `rst` while `is_compute` is high, the mask is 3'b111 and a nonzero target is applied, so a branch would be taken if reset were absent. The scoreboard expects 0x0000 after that edge, not the target. A second overlap is a jump to 0xFFFF followed by an advance, which must wrap to zero. The bench judges this the same way, by comparing with the value its model predicts.

// File: rtl/pcj_pkg.sv
package pcj_pkg;

    localparam int unsigned MASK_W = 3;

    // Bit positions within the jump mask (they fix which relation each bit enables)
    localparam int unsigned BIT_NEG  = 2;
    localparam int unsigned BIT_ZERO = 1;
    localparam int unsigned BIT_POS  = 0;

    typedef enum logic [1:0] {
        STEP_CLEAR   = 2'd0,
        STEP_BRANCH  = 2'd1,
        STEP_ADVANCE = 2'd2
    } step_t;

endpackage

// File: rtl/pcj_cond_eval.sv
module pcj_cond_eval
    import pcj_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0]      result,
    input  logic [MASK_W-1:0] mask,
    output logic              hit
);

    logic             is_neg;
    logic             is_zero;
    logic             is_pos;
    logic [MASK_W-1:0] relation;
    logic [MASK_W-1:0] term;

    always_comb begin
        is_neg  = result[W-1];
        is_zero = (result == '0);
        is_pos  = !is_neg && !is_zero;
        relation = '0;
        relation[BIT_NEG]  = is_neg;
        relation[BIT_ZERO] = is_zero;
        relation[BIT_POS]  = is_pos;
    end

    for (genvar g = 0; g < MASK_W; g++) begin : g_term
        assign term[g] = relation[g] & mask[g];
    end

    assign hit = |term;

    // R9: the result belongs to exactly one class
    always_comb begin
        p_one_class_r9: assert ($onehot({is_neg, is_zero, is_pos}));
    end

    // R5: the two mask extremes
    always_comb begin
        if (mask == {MASK_W{1'b0}}) begin
            p_never_r5: assert (!hit);
        end
        if (mask == {MASK_W{1'b1}}) begin
            p_always_r5: assert (hit);
        end
    end

endmodule

// File: rtl/pcj_step_sel.sv
module pcj_step_sel
    import pcj_pkg::*;
(
    input  logic  rst,
    input  logic  is_compute,
    input  logic  hit,
    output step_t step
);

    always_comb begin
        step = STEP_ADVANCE;
        unique casez ({rst, is_compute, hit})
            3'b1??:  step = STEP_CLEAR;
            3'b011:  step = STEP_BRANCH;
            3'b010,
            3'b00?:  step = STEP_ADVANCE;
            default: step = STEP_ADVANCE;
        endcase
    end

    // R6: an address instruction never selects a branch
    always_comb begin
        if (!is_compute) begin
            p_no_addr_jump_r6: assert (step != STEP_BRANCH);
        end
    end

endmodule

// File: rtl/pcj_count_reg.sv
module pcj_count_reg
    import pcj_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  step_t        step,
    input  logic [W-1:0] target,
    output logic [W-1:0] pc
);

    logic [W-1:0] pc_q;
    logic [W-1:0] pc_d;

    // State register
    always_ff @(posedge clk) begin
        pc_q <= pc_d;
    end

    // Next-value process
    always_comb begin
        pc_d = pc_q;
        unique case (step)
            STEP_CLEAR:   pc_d = '0;
            STEP_BRANCH:  pc_d = target;
            STEP_ADVANCE: pc_d = pc_q + W'(1);
            default:      pc_d = pc_q + W'(1);
        endcase
    end

    assign pc = pc_q;

    // R1: a clear edge leaves zero behind
    logic rst_q;
    always_ff @(posedge clk) begin
        rst_q <= rst;
    end
    always @(negedge clk) begin
        if (rst_q === 1'b1) begin
            p_clear_zero_r1: assert (pc_q == '0);
        end
    end

    // R7: a branch loads the target
    property branch_load;
        @(posedge clk) disable iff (rst)
        (step == STEP_BRANCH) |=> (pc_q == $past(target));
    endproperty
    p_branch_load_r7: assert property (branch_load);

    // R8: an advance adds one, with wrap
    property advance_one;
        @(posedge clk) disable iff (rst)
        (step == STEP_ADVANCE) |=> (pc_q == $past(pc_q) + W'(1));
    endproperty
    p_advance_one_r8: assert property (advance_one);

endmodule

// File: rtl/pcj_jump_pc.sv
module pcj_jump_pc
    import pcj_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [W-1:0]      alu_result,
    input  logic [W-1:0]      jump_target,
    input  logic              is_compute,
    input  logic [MASK_W-1:0] jump_mask,
    output logic [W-1:0]      pc_out
);

    logic  cond_hit;
    step_t step;

    pcj_cond_eval #(.W(W)) u_cond (
        .result (alu_result),
        .mask   (jump_mask),
        .hit    (cond_hit)
    );

    pcj_step_sel u_sel (
        .rst        (rst),
        .is_compute (is_compute),
        .hit        (cond_hit),
        .step       (step)
    );

    pcj_count_reg #(.W(W)) u_reg (
        .clk    (clk),
        .rst    (rst),
        .step   (step),
        .target (jump_target),
        .pc     (pc_out)
    );

endmodule

// File: tb/tb_pcj_jump_pc.sv
module tb_pcj_jump_pc;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] alu_result = '0;
    logic [15:0] jump_target = '0;
    logic        is_compute = 1'b0;
    logic [2:0]  jump_mask = '0;
    logic [15:0] pc_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] model_pc = '0;

    always #5 clk = ~clk;

    pcj_jump_pc dut (
        .clk         (clk),
        .rst         (rst),
        .alu_result  (alu_result),
        .jump_target (jump_target),
        .is_compute  (is_compute),
        .jump_mask   (jump_mask),
        .pc_out      (pc_out)
    );

    function automatic bit cond(input logic [15:0] r, input logic [2:0] m);
        bit neg  = r[15];
        bit zero = (r == 16'h0000);
        bit pos  = !neg && !zero;
        return (m[2] && neg) || (m[1] && zero) || (m[0] && pos);
    endfunction

    // Driver: applies one cycle of stimulus and pushes the expected PC
    task automatic step(input bit r, input logic [15:0] res, input logic [15:0] tgt,
                        input bit comp, input logic [2:0] m, input string tag);
        @(negedge clk);
        rst         = r;
        alu_result  = res;
        jump_target = tgt;
        is_compute  = comp;
        jump_mask   = m;
        if (r)                    model_pc = 16'h0000;
        else if (comp && cond(res, m)) model_pc = tgt;
        else                      model_pc = model_pc + 16'h0001;
        exp_q.push_back(model_pc);
        tag_q.push_back(tag);
    endtask

    // Monitor: compares after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (pc_out !== e) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h", t, pc_out, e);
                end
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        step(1, 16'h0005, 16'h1234, 1, 3'b111, "R1 reset");
        step(1, 16'h0005, 16'h1234, 1, 3'b111, "R1 reset held");
        // R8 increment
        step(0, 16'h0005, 16'h1234, 1, 3'b000, "R8 advance");
        step(0, 16'h0005, 16'h1234, 1, 3'b000, "R8 advance 2");
        // R2 negative
        step(0, 16'h8000, 16'h0100, 1, 3'b100, "R2 neg jump");
        step(0, 16'h0001, 16'h0200, 1, 3'b100, "R2 pos no jump");
        step(0, 16'h0000, 16'h0200, 1, 3'b100, "R2 zero no jump");
        // R3 zero
        step(0, 16'h0000, 16'h0300, 1, 3'b010, "R3 zero jump");
        step(0, 16'hFFFF, 16'h0400, 1, 3'b010, "R3 neg no jump");
        // R4 positive
        step(0, 16'h7FFF, 16'h0500, 1, 3'b001, "R4 pos jump");
        step(0, 16'h0000, 16'h0600, 1, 3'b001, "R4 zero no jump");
        step(0, 16'h8001, 16'h0600, 1, 3'b001, "R4 neg no jump");
        // R9 combined masks
        step(0, 16'h0000, 16'h0700, 1, 3'b101, "R9 ne with zero");
        step(0, 16'h9000, 16'h0800, 1, 3'b101, "R9 ne with neg");
        step(0, 16'h0042, 16'h0900, 1, 3'b110, "R9 le with pos");
        step(0, 16'h0000, 16'h0A00, 1, 3'b011, "R9 ge with zero");
        // R5 extremes
        step(0, 16'h0000, 16'h0B00, 1, 3'b111, "R5 always zero");
        step(0, 16'hC000, 16'h0C00, 1, 3'b111, "R5 always neg");
        step(0, 16'h0010, 16'h0D00, 1, 3'b111, "R5 always pos");
        step(0, 16'h0000, 16'h0E00, 1, 3'b000, "R5 never");
        // R6 address instruction
        step(0, 16'h0000, 16'h0F00, 0, 3'b111, "R6 addr zero");
        step(0, 16'h8000, 16'h0F00, 0, 3'b111, "R6 addr neg");
        step(0, 16'h0001, 16'h0F00, 0, 3'b001, "R6 addr pos");
        // R7 and R8 wrap
        step(0, 16'h0000, 16'hFFFF, 1, 3'b010, "R7 jump to top");
        step(0, 16'h0001, 16'h1111, 1, 3'b000, "R8 wrap");
        step(0, 16'h0001, 16'h1111, 1, 3'b000, "R8 after wrap");
        // R1 overlap with branch
        step(0, 16'h0000, 16'h2222, 1, 3'b000, "R8 before clear");
        step(1, 16'h0000, 16'h3333, 1, 3'b111, "R1 clear beats jump");
        step(0, 16'h0000, 16'h4444, 1, 3'b010, "R7 after clear");
        step(0, 16'h0000, 16'h4444, 0, 3'b000, "R8 after jump");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule